// File: doc/BRIEF.md
# Burst Write Endpoint

This block sits on the bus side of a simplified master-write handshake. User logic offers a command, made of a request strobe, a transfer-type bit, a byte address and a byte length. The block samples the command, acknowledges it with a one-cycle pulse, and then takes 32-bit data beats under active-low ready handshakes in both directions. Each beat it accepts is stored in a small internal word memory, starting at the word that the commanded address selects.

The block checks the active-low start and end frame markers on every accepted beat. It keeps sticky flags for framing faults and for malformed commands. Its own ready output can be throttled by a fixed stall pattern, so the requester's handling of backpressure gets exercised. A combinational read port returns any stored word, which lets the memory contents be inspected after each transaction.

Top module: `burst_write_sink`

## Requirements
- R1: After a synchronous reset (rstN low at a clock edge), cmdAck is 0, dstRdyN is 1, frameErr is 0 and cmdErr is 0. Reset does not change the memory.
- R2: In idle, a clock edge with wrReq=1 samples burstType, cmdAddr and cmdLen together. cmdAck is then 1 for exactly the next cycle, and dstRdyN stays 1 during that cycle. No beat is accepted before the acknowledge.
- R3: burstType=1 selects a fixed-length burst of cmdLen/4 beats. burstType=0 selects exactly one beat, whatever cmdLen holds.
- R4: A beat is consumed at a clock edge where dstRdyN=0 and srcRdyN=0. Beat k of a transaction is written to word index (cmdAddr/4 + k) mod MEM_WORDS.
- R5: In a data-phase cycle with srcRdyN=1, nothing is stored and the beat position does not advance.
- R6: dstRdyN is 1 outside the data phase. In data-phase cycle n (counted from 0 after the acknowledge), dstRdyN equals bit (n mod 4) of STALL_PATTERN. The default pattern 4'b0100 stalls the third cycle of every four.
- R7: frameErr is set, and stays set until reset, when an accepted beat breaks framing. The four faults are: sofN=1 on the first beat, sofN=0 on a later beat, eofN=0 before the last beat, and eofN=1 on the last beat. Such a beat is still stored.
- R8: cmdErr is set, and stays set until reset, when a command has cmdAddr[1:0]!=0, or when it is a burst whose cmdLen is zero or not a multiple of 4. Such a command is still acknowledged, but it has no data phase and leaves the memory unchanged.
- R9: After the edge that consumes the last beat, the block is idle again. A command presented in that very next cycle is sampled at the following edge.
- R10: rdData shows, combinationally, the stored word at index rdAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| wrReq | input | 1 | Write command request |
| burstType | input | 1 | 1 = fixed-length burst, 0 = single beat |
| cmdAddr | input | $clog2(MEM_WORDS)+2 | Byte address of the first beat |
| cmdLen | input | LEN_W | Transfer length in bytes |
| cmdAck | output | 1 | One-cycle command acknowledge |
| wrData | input | DATA_W | Data beat |
| srcRdyN | input | 1 | Source ready, active low |
| sofN | input | 1 | Start-of-frame marker, active low |
| eofN | input | 1 | End-of-frame marker, active low |
| dstRdyN | output | 1 | Destination ready, active low |
| rdAddr | input | $clog2(MEM_WORDS) | Read-back word index |
| rdData | output | DATA_W | Read-back word |
| frameErr | output | 1 | Sticky framing fault flag |
| cmdErr | output | 1 | Sticky malformed-command flag |

## Verification
The two throttles can meet in one cycle: the source can hold srcRdyN high in a cycle where the stall pattern also holds dstRdyN high, or in a cycle where dstRdyN is low. The bench drives source stalls at a period different from the four-cycle stall pattern, so both overlaps occur within a single burst. In every data-phase cycle the bench compares dstRdyN with the pattern bit for that cycle. At the end it judges the memory words through the scoreboard: each word must hold the next value of a consecutive sequence, with no gap and no repeat. A second overlap sits on the final beat. That beat's transfer ends the transaction, and the bench presents the next command in the following cycle and checks that the command is acknowledged without delay.

// File: rtl/bws_pkg.sv
package bws_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ACK, PH_DATA} phase_e;

  typedef struct packed {
    logic capture;  // load the base word index from the command
    logic we;       // store the current beat and advance
    logic first;    // current beat is the first of the transaction
    logic last;     // current beat is the last of the transaction
  } strobe_t;
endpackage

// File: rtl/bws_ctrl.sv
module bws_ctrl #(
  parameter int LEN_W = 12,
  parameter logic [3:0] STALL_PATTERN = 4'b0100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrReq,
  input  logic             burstType,
  input  logic [1:0]       addrLow,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             srcRdyN,
  output logic             cmdAck,
  output logic             dstRdyN,
  output logic             cmdErr,
  output bws_pkg::strobe_t strb
);
  import bws_pkg::*;

  localparam int CNT_W = LEN_W - 2;

  phase_e           phase;
  logic [CNT_W-1:0] totalBeats;
  logic [CNT_W-1:0] beatIdx;
  logic [1:0]       stallCnt;
  logic             badCmd;
  logic             cmdBad;
  logic             xfer;
  logic             lastBeat;

  always_comb begin
    cmdBad   = (addrLow != 2'b00) ||
               (burstType && ((cmdLen == '0) || (cmdLen[1:0] != 2'b00)));
    dstRdyN  = (phase == PH_DATA) ? STALL_PATTERN[stallCnt] : 1'b1;
    cmdAck   = (phase == PH_ACK);
    xfer     = (phase == PH_DATA) && !dstRdyN && !srcRdyN;
    lastBeat = (beatIdx + 1'b1) == totalBeats;
    strb.capture = (phase == PH_IDLE) && wrReq;
    strb.we      = xfer;
    strb.first   = (beatIdx == '0);
    strb.last    = lastBeat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      totalBeats <= '0;
      beatIdx    <= '0;
      stallCnt   <= '0;
      badCmd     <= 1'b0;
      cmdErr     <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (wrReq) begin
          totalBeats <= burstType ? cmdLen[LEN_W-1:2] : CNT_W'(1);
          badCmd     <= cmdBad;
          if (cmdBad) cmdErr <= 1'b1;
          phase <= PH_ACK;
        end
        PH_ACK: begin
          beatIdx  <= '0;
          stallCnt <= '0;
          phase    <= badCmd ? PH_IDLE : PH_DATA;
        end
        PH_DATA: begin
          stallCnt <= stallCnt + 1'b1;
          if (xfer) begin
            beatIdx <= beatIdx + 1'b1;
            if (lastBeat) phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Acknowledge lasts one cycle only
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdAck |=> !cmdAck);

  // No beat may be offered a ready while the acknowledge is up
  p_ack_no_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdAck |-> dstRdyN);

  // Entry into the data phase is always preceded by the acknowledge
  p_ack_before_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phase == PH_DATA) |-> $past(cmdAck));

  // A source stall freezes the beat position
  p_src_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA && srcRdyN) |=> $stable(beatIdx));

  // After the final beat the endpoint is idle: no ready, no acknowledge
  p_last_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && lastBeat) |=> (dstRdyN && !cmdAck));

  // Command error flag is sticky
  p_cmd_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |=> cmdErr);
endmodule

// File: rtl/bws_dpath.sv
module bws_dpath #(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  bws_pkg::strobe_t             strb,
  input  logic [$clog2(MEM_WORDS)-1:0] baseIdx,
  input  logic [DATA_W-1:0]            wrData,
  input  logic                         sofN,
  input  logic                         eofN,
  input  logic [$clog2(MEM_WORDS)-1:0] rdAddr,
  output logic [DATA_W-1:0]            rdData,
  output logic                         frameErr
);
  localparam int IDX_W = $clog2(MEM_WORDS);

  logic [DATA_W-1:0] mem [MEM_WORDS];
  logic [IDX_W-1:0]  ptr;
  logic              badFrame;

  always_comb begin
    // marker is active low: first beat wants sofN=0, others sofN=1
    badFrame = (strb.first == sofN) || (strb.last == eofN);
    rdData   = mem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr      <= '0;
      frameErr <= 1'b0;
    end else begin
      if (strb.capture) ptr <= baseIdx;
      else if (strb.we) ptr <= ptr + 1'b1;
      if (strb.we && badFrame) frameErr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.we) mem[ptr] <= wrData;
  end

  // Every accepted beat lands at the pointer it was aimed at
  p_store_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.we |=> (mem[$past(ptr)] == $past(wrData)));

  // Framing error flag is sticky
  p_frame_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> frameErr);
endmodule

// File: rtl/burst_write_sink.sv
module burst_write_sink #(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64,
  parameter int LEN_W     = 12,
  parameter logic [3:0] STALL_PATTERN = 4'b0100
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrReq,
  input  logic                         burstType,
  input  logic [$clog2(MEM_WORDS)+1:0] cmdAddr,
  input  logic [LEN_W-1:0]             cmdLen,
  output logic                         cmdAck,
  input  logic [DATA_W-1:0]            wrData,
  input  logic                         srcRdyN,
  input  logic                         sofN,
  input  logic                         eofN,
  output logic                         dstRdyN,
  input  logic [$clog2(MEM_WORDS)-1:0] rdAddr,
  output logic [DATA_W-1:0]            rdData,
  output logic                         frameErr,
  output logic                         cmdErr
);
  localparam int IDX_W = $clog2(MEM_WORDS);

  bws_pkg::strobe_t strb;

  bws_ctrl #(.LEN_W(LEN_W), .STALL_PATTERN(STALL_PATTERN)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .burstType(burstType),
    .addrLow(cmdAddr[1:0]), .cmdLen(cmdLen), .srcRdyN(srcRdyN),
    .cmdAck(cmdAck), .dstRdyN(dstRdyN), .cmdErr(cmdErr), .strb(strb)
  );

  bws_dpath #(.DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .baseIdx(cmdAddr[IDX_W+1:2]),
    .wrData(wrData), .sofN(sofN), .eofN(eofN), .rdAddr(rdAddr),
    .rdData(rdData), .frameErr(frameErr)
  );
endmodule

// File: tb/test_burst_write_sink.sv
`timescale 1ns/1ps
module test_burst_write_sink;
  localparam int DATA_W = 32;
  localparam int MEM_WORDS = 64;
  localparam int LEN_W = 12;
  localparam logic [3:0] PAT = 4'b0100;

  logic clk = 1'b0;
  logic rstN, wrReq, burstType, srcRdyN, sofN, eofN;
  logic [7:0] cmdAddr;
  logic [LEN_W-1:0] cmdLen;
  logic [DATA_W-1:0] wrData, rdData;
  logic [5:0] rdAddr;
  logic cmdAck, dstRdyN, frameErr, cmdErr;

  int nTests = 0, nFail = 0;
  bit done = 0;

  typedef struct { int idx; logic [31:0] val; string req; } item_t;
  item_t sb[$];
  logic [31:0] expMem [MEM_WORDS];

  burst_write_sink i_burst_write_sink (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .burstType(burstType),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .cmdAck(cmdAck), .wrData(wrData),
    .srcRdyN(srcRdyN), .sofN(sofN), .eofN(eofN), .dstRdyN(dstRdyN),
    .rdAddr(rdAddr), .rdData(rdData), .frameErr(frameErr), .cmdErr(cmdErr)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expectWord(input int idx, input logic [31:0] v, input string req);
    item_t it;
    it.idx = idx % MEM_WORDS; it.val = v; it.req = req;
    expMem[it.idx] = v;
    sb.push_back(it);
  endtask

  // monitor side of the scoreboard: pops and compares via the read port
  task automatic drain();
    while (sb.size() > 0) begin
      item_t it = sb.pop_front();
      @(negedge clk);
      rdAddr = 6'(it.idx);
      #1;
      check(rdData === it.val, it.req, $sformatf("word %0d", it.idx), rdData, it.val);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; wrReq = 0; srcRdyN = 1; sofN = 1; eofN = 1;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  // ends on the negedge of the acknowledge cycle
  task automatic issueCmd(input logic [7:0] a, input logic [LEN_W-1:0] l,
                          input logic t, input string req);
    @(negedge clk);
    srcRdyN = 1; sofN = 1; eofN = 1;
    check(cmdAck == 0 && dstRdyN == 1, req, "idle before command", {cmdAck, dstRdyN}, 2'b01);
    wrReq = 1; cmdAddr = a; cmdLen = l; burstType = t;
    @(negedge clk);
    wrReq = 0; cmdAddr = '0; cmdLen = '0; burstType = 0;
    check(cmdAck == 1 && dstRdyN == 1, "R2", "ack cycle", {cmdAck, dstRdyN}, 2'b11);
  endtask

  // badMode: 1 missing sof, 2 extra sof, 3 early eof, 4 missing eof
  task automatic streamBeats(input int n, input int base, input logic [31:0] seed,
                             input int stallEvery, input int badMode, input string req);
    int sent = 0;
    int cyc = 0;
    while (sent < n) begin
      bit srcStall;
      @(negedge clk);
      if (cyc == 0) check(cmdAck == 0, "R2", "ack pulse width", cmdAck, 0);
      check(dstRdyN == PAT[cyc % 4], "R6", $sformatf("stall pattern cycle %0d", cyc),
            dstRdyN, PAT[cyc % 4]);
      srcStall = (stallEvery != 0) && (cyc % stallEvery == 1);
      srcRdyN = srcStall;
      wrData = seed + sent;
      sofN = (sent != 0);
      eofN = (sent != n - 1);
      if (badMode == 1 && sent == 0) sofN = 1;
      if (badMode == 2 && sent == 1) sofN = 0;
      if (badMode == 3 && sent == n - 2) eofN = 0;
      if (badMode == 4 && sent == n - 1) eofN = 1;
      if (!dstRdyN && !srcStall) begin
        expectWord(base + sent, seed + sent, req);
        sent++;
      end
      cyc++;
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 0; wrReq = 0; burstType = 0; cmdAddr = '0; cmdLen = '0;
    wrData = '0; srcRdyN = 1; sofN = 1; eofN = 1; rdAddr = '0;
    doReset();
    @(negedge clk);
    check(cmdAck == 0 && dstRdyN == 1 && frameErr == 0 && cmdErr == 0, "R1",
          "reset state", {cmdAck, dstRdyN, frameErr, cmdErr}, 4'b0100);

    // R3 R4 R6: 4-beat burst at word 10, no source stalls
    issueCmd(8'h28, 12'd16, 1'b1, "R9");
    streamBeats(4, 10, 32'hA000_0000, 0, 0, "R4");
    // R9 R5: back-to-back 6-beat burst at word 20 with source stalls
    issueCmd(8'h50, 12'd24, 1'b1, "R9");
    streamBeats(6, 20, 32'hB000_0000, 3, 0, "R5");
    issueCmd(8'h00, 12'd0, 1'b0, "R9");  // single beat, length ignored
    streamBeats(1, 0, 32'hC000_0000, 0, 0, "R3");
    @(negedge clk);
    check(frameErr == 0 && cmdErr == 0, "R7", "clean frames leave flags low",
          {frameErr, cmdErr}, 0);
    drain();

    // R3: single beat with a burst-sized length overwrites only word 10
    issueCmd(8'h28, 12'd16, 1'b0, "R3");
    streamBeats(1, 10, 32'hD000_0000, 0, 0, "R3");
    expectWord(11, expMem[11], "R3");
    drain();

    // R4: wrap around the end of the memory
    issueCmd(8'hF8, 12'd16, 1'b1, "R4");
    streamBeats(4, 62, 32'hE000_0000, 2, 0, "R4");
    drain();

    // R8: misaligned address and bad length
    issueCmd(8'h29, 12'd16, 1'b1, "R8");
    @(negedge clk);
    check(cmdErr == 1 && dstRdyN == 1, "R8", "misaligned rejected", {cmdErr, dstRdyN}, 2'b11);
    @(negedge clk);
    check(dstRdyN == 1 && cmdAck == 0, "R8", "no data phase", {dstRdyN, cmdAck}, 2'b10);
    expectWord(10, expMem[10], "R8");
    drain();
    doReset();
    @(negedge clk);
    check(cmdErr == 0, "R1", "reset clears cmdErr", cmdErr, 0);
    issueCmd(8'h30, 12'd6, 1'b1, "R8");
    @(negedge clk);
    check(cmdErr == 1 && dstRdyN == 1, "R8", "length not multiple of 4", {cmdErr, dstRdyN}, 2'b11);
    doReset();
    issueCmd(8'h30, 12'd0, 1'b1, "R8");
    @(negedge clk);
    check(cmdErr == 1, "R8", "zero burst length", cmdErr, 1);
    expectWord(12, expMem[12], "R8");
    drain();

    // R7: four framing faults, each after a reset
    for (int m = 1; m <= 4; m++) begin
      doReset();
      @(negedge clk);
      check(frameErr == 0, "R1", "reset clears frameErr", frameErr, 0);
      issueCmd(8'h80, 12'd12, 1'b1, "R7");
      streamBeats(3, 32, 32'hF000_0000 + (m << 8), 0, m, "R7");
      @(negedge clk);
      check(frameErr == 1, "R7", $sformatf("fault mode %0d", m), frameErr, 1);
      @(negedge clk);
      check(frameErr == 1, "R7", "flag sticky", frameErr, 1);
      drain();
    end

    // R10: read port follows rdAddr without a clock
    @(negedge clk);
    rdAddr = 6'd21; #1;
    check(rdData === expMem[21], "R10", "read word 21", rdData, expMem[21]);
    rdAddr = 6'd63; #1;
    check(rdData === expMem[63], "R10", "read word 63", rdData, expMem[63]);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule